// File: doc/BRIEF.md
# Compare-Match Output Pin Override Unit

This block keeps the compare-output state bit of one 8-bit timer channel and chooses what a general-purpose pin carries: the normal port data bit, or that state bit. The state bit is a register of its own, separate from the pin. A two-bit mode field sets how the bit reacts to a compare-match event. Any nonzero mode routes the bit to the pin in place of the port data. Whether the pin drives at all is always decided by the direction bit alone.

The timer's comparator sends a one-cycle match strobe. Software may also raise a force strobe, which has the same effect as a match, or preset the state bit to a known level. A preset done before the pin is enabled lets the pin start from a defined value. The port data and direction bits are registers that are written through strobes. The state bit is visible on its own readback output, which never reflects the pin.

Top module: `ocPinOverride`

## Requirements
- R1: After reset the compare state, port data and direction bits are all 0, so pinOe = 0, pinOut = 0 and cmpState = 0.
- R2: With modeSel = 2'b01, a match or force event inverts cmpState at the next clock edge.
- R3: With modeSel = 2'b10, a match or force event drives cmpState to 0 at the next clock edge.
- R4: With modeSel = 2'b11, a match or force event drives cmpState to 1 at the next clock edge.
- R5: With modeSel = 2'b00, match and force events leave cmpState unchanged.
- R6: When modeSel is nonzero, pinOut equals cmpState. When modeSel is 2'b00, pinOut equals the port data register. The selection is combinational on modeSel.
- R7: pinOe always equals the direction register, whatever the mode.
- R8: A force event acts exactly like a match under the current mode. A match and a force in the same cycle produce a single update, so toggle mode inverts the bit only once.
- R9: A preset write (presetWr) loads presetVal into cmpState at the next edge, and it takes priority over a match or force event in the same cycle.
- R10: cmpState reads back the internal state register and not the pin level, including when the pin shows port data or is not driven.
- R11: portWr and dirWr load portVal and dirVal at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | I/O clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Compare output mode: 00 off, 01 toggle, 10 clear, 11 set |
| matchEvt | input | 1 | One-cycle compare-match strobe from the comparator |
| forceEvt | input | 1 | One-cycle force-compare strobe |
| presetWr | input | 1 | Write strobe that presets the compare state |
| presetVal | input | 1 | Value loaded by presetWr |
| portWr | input | 1 | Write strobe for the port data register |
| portVal | input | 1 | Value loaded by portWr |
| dirWr | input | 1 | Write strobe for the direction register |
| dirVal | input | 1 | Value loaded by dirWr (1 = output) |
| pinOut | output | 1 | Value presented to the pin driver |
| pinOe | output | 1 | Pin output enable |
| cmpState | output | 1 | Readback of the internal compare state register |

## Verification
Every register update (compare state, port data, direction) appears one clock edge after the strobe that causes it. The route select from modeSel to pinOut is combinational, so it can be seen in the same cycle. The bench changes inputs on the falling edge and samples on the next falling edge, which lands half a period after the rising edge that made the update. A behavioural model, updated on the same rising edge, is compared against all three outputs on every falling edge. Directed checks with fixed expected values cover each mode, the double-strobe case, preset priority and readback isolation.

// File: rtl/ocPinPkg.sv
package ocPinPkg;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_TOGGLE = 2'b01,
    MODE_CLEAR  = 2'b10,
    MODE_SET    = 2'b11
  } ocMode_e;

  // Strobes from control to datapath; at most one state action per cycle
  typedef struct packed {
    logic load;    // preset write wins
    logic toggle;
    logic clear;
    logic set;
    logic route;   // pin carries compare state
  } ocStrobe_t;

endpackage

// File: rtl/ocPinCtrl.sv
module ocPinCtrl
  import ocPinPkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic [MODE_W-1:0] modeSel,
  input  logic              matchEvt,
  input  logic              forceEvt,
  input  logic              presetWr,
  output ocStrobe_t         strobe
);

  logic    anyEvt;
  logic    evtTaken;
  ocMode_e modeQ;

  always_comb begin
    modeQ    = ocMode_e'(modeSel);
    anyEvt   = matchEvt | forceEvt;
    evtTaken = anyEvt & ~presetWr;
    strobe        = '0;
    strobe.load   = presetWr;
    strobe.route  = |modeSel;
    unique case (modeQ)
      MODE_TOGGLE: strobe.toggle = evtTaken;
      MODE_CLEAR:  strobe.clear  = evtTaken;
      MODE_SET:    strobe.set    = evtTaken;
      default:     ;
    endcase
  end

endmodule

// File: rtl/ocPinDatapath.sv
module ocPinDatapath
  import ocPinPkg::*;
#(
  parameter logic STATE_RST = 1'b0,
  parameter logic PORT_RST  = 1'b0,
  parameter logic DIR_RST   = 1'b0
) (
  input  logic      clk,
  input  logic      rstN,
  input  ocStrobe_t strobe,
  input  logic      presetVal,
  input  logic      portWr,
  input  logic      portVal,
  input  logic      dirWr,
  input  logic      dirVal,
  output logic      pinOut,
  output logic      pinOe,
  output logic      stateOut
);

  logic stateQ, stateD;
  logic portQ, dirQ;

  always_comb begin
    stateD = stateQ;
    if (strobe.load)        stateD = presetVal;
    else if (strobe.toggle) stateD = ~stateQ;
    else if (strobe.clear)  stateD = 1'b0;
    else if (strobe.set)    stateD = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= STATE_RST;
      portQ  <= PORT_RST;
      dirQ   <= DIR_RST;
    end else begin
      stateQ <= stateD;
      if (portWr) portQ <= portVal;
      if (dirWr)  dirQ  <= dirVal;
    end
  end

  assign pinOut   = strobe.route ? stateQ : portQ;
  assign pinOe    = dirQ;
  assign stateOut = stateQ;

  // R9: control never issues a preset together with an event action
  p_single_action_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.toggle, strobe.clear, strobe.set}));

  // R11: direction write lands on pinOe one edge later
  p_dir_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    dirWr |=> (pinOe == $past(dirVal)));

  // R7: enable changes only through a direction write
  p_oe_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dirWr |=> $stable(pinOe));

endmodule

// File: rtl/ocPinOverride.sv
module ocPinOverride
  import ocPinPkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              matchEvt,
  input  logic              forceEvt,
  input  logic              presetWr,
  input  logic              presetVal,
  input  logic              portWr,
  input  logic              portVal,
  input  logic              dirWr,
  input  logic              dirVal,
  output logic              pinOut,
  output logic              pinOe,
  output logic              cmpState
);

  ocStrobe_t strobe;

  ocPinCtrl #(.MODE_W(MODE_W)) u_ctrl (
    .modeSel  (modeSel),
    .matchEvt (matchEvt),
    .forceEvt (forceEvt),
    .presetWr (presetWr),
    .strobe   (strobe)
  );

  ocPinDatapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .presetVal (presetVal),
    .portWr    (portWr),
    .portVal   (portVal),
    .dirWr     (dirWr),
    .dirVal    (dirVal),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .stateOut  (cmpState)
  );

  logic evtIn;
  assign evtIn = (matchEvt | forceEvt) & ~presetWr;

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn && modeSel == 2'b01) |=> (cmpState != $past(cmpState)));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn && modeSel == 2'b10) |=> !cmpState);

  p_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evtIn && modeSel == 2'b11) |=> cmpState);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!presetWr && modeSel == 2'b00) |=> $stable(cmpState));

  p_preset_r9: assert property (@(posedge clk) disable iff (!rstN)
    presetWr |=> (cmpState == $past(presetVal)));

  // R6: with a nonzero mode the pin carries the readback state
  p_route_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'b00) |-> (pinOut == cmpState));

endmodule

// File: tb/test_ocPinOverride.sv
module test_ocPinOverride;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic matchEvt = 0, forceEvt = 0, presetWr = 0, presetVal = 0;
  logic portWr = 0, portVal = 0, dirWr = 0, dirVal = 0;
  logic pinOut, pinOe, cmpState;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ocPinOverride i_ocPinOverride (
    .clk, .rstN, .modeSel, .matchEvt, .forceEvt, .presetWr, .presetVal,
    .portWr, .portVal, .dirWr, .dirVal, .pinOut, .pinOe, .cmpState
  );

  // Behavioural reference model
  int mState, mPort, mDir;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mPort = 0; mDir = 0;
    end else begin
      if (presetWr) mState = presetVal;
      else if (matchEvt || forceEvt) begin
        if (modeSel == 2'd1) mState = 1 - mState;
        else if (modeSel == 2'd2) mState = 0;
        else if (modeSel == 2'd3) mState = 1;
      end
      if (portWr) mPort = portVal;
      if (dirWr)  mDir  = dirVal;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the rising edge
  always @(negedge clk) if (rstN && !done) begin
    chk("R6 model pinOut", pinOut, (modeSel != 0) ? mState[0] : mPort[0]);
    chk("R7 model pinOe", pinOe, mDir[0]);
    chk("R10 model cmpState", cmpState, mState[0]);
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    matchEvt = 0; forceEvt = 0; presetWr = 0; portWr = 0; dirWr = 0;
  endtask

  task automatic finish();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmpState", cmpState, 1'b0);
    chk("R1 pinOe", pinOe, 1'b0);
    chk("R1 pinOut", pinOut, 1'b0);
    rstN = 1;
    @(negedge clk);

    portWr = 1; portVal = 1; dirWr = 1; dirVal = 1; step();
    chk("R11 pinOe", pinOe, 1'b1);
    chk("R6 pinOut port", pinOut, 1'b1);

    modeSel = 2'b01; #1;
    chk("R6 pinOut state", pinOut, 1'b0);
    @(negedge clk);

    matchEvt = 1; step();
    chk("R2 toggle up", cmpState, 1'b1);
    matchEvt = 1; step();
    chk("R2 toggle down", cmpState, 1'b0);
    forceEvt = 1; step();
    chk("R8 force toggles", cmpState, 1'b1);
    matchEvt = 1; forceEvt = 1; step();
    chk("R8 double strobe once", cmpState, 1'b0);

    modeSel = 2'b11; matchEvt = 1; step();
    chk("R4 set", cmpState, 1'b1);
    chk("R6 pin follows", pinOut, 1'b1);
    modeSel = 2'b10; forceEvt = 1; step();
    chk("R3 clear via force", cmpState, 1'b0);

    modeSel = 2'b00; presetWr = 1; presetVal = 1; step();
    chk("R9 preset", cmpState, 1'b1);
    portWr = 1; portVal = 0; step();
    chk("R6 port shown", pinOut, 1'b0);
    chk("R10 readback not pin", cmpState, 1'b1);
    matchEvt = 1; forceEvt = 1; step();
    chk("R5 off holds", cmpState, 1'b1);

    modeSel = 2'b10; presetWr = 1; presetVal = 1; matchEvt = 1; step();
    chk("R9 preset beats match", cmpState, 1'b1);

    modeSel = 2'b11; dirWr = 1; dirVal = 0; presetWr = 1; presetVal = 0; step();
    chk("R7 oe off in mode 11", pinOe, 1'b0);
    chk("R10 readback undriven", cmpState, 1'b0);
    dirWr = 1; dirVal = 1; step();
    chk("R11 dir on", pinOe, 1'b1);
    chk("R6 preset level shown", pinOut, 1'b0);

    for (int i = 0; i < 400; i++) begin
      modeSel  = 2'($urandom_range(3));
      matchEvt = 1'($urandom_range(1));
      forceEvt = ($urandom_range(3) == 0);
      presetWr = ($urandom_range(4) == 0);
      presetVal = 1'($urandom_range(1));
      portWr = ($urandom_range(3) == 0);
      portVal = 1'($urandom_range(1));
      dirWr = ($urandom_range(5) == 0);
      dirVal = 1'($urandom_range(1));
      step();
    end

    finish();
  end

endmodule